// File: doc/BRIEF.md
# Banked Clock Divider with Alignment Marker

This block turns one fast source clock into three banks of divided clock outputs, four pins per bank. Each bank picks its own divide ratio with a two-bit select: divide by 2, 4, 6 or 8. All dividers run from one shared time base, and every output register updates on the same source-clock edge, so the banks stay in phase with each other.

A separate marker output, `sync`, flags the instants where a rising edge of bank A coincides with a rising edge of bank C. It works for any ratio the selects can form: 1:1, 2:1, 3:1, 3:2, 4:1 and 4:3, with either bank as the faster one. Select changes are held back until the shared time base wraps. That wrap is a point where every bank is at a rising edge, so no output ever produces a shortened pulse.

All pins are plain level signals. There is no data stream and no handshake.

Top module: `banked_clk_div`

## Requirements
- R1: While `rst_n` is sampled low on a rising `clk` edge, every bank output and `sync` are low after that edge.
- R2: Select encoding per bank: 00 divides by 2, 01 by 4, 10 by 6, 11 by 8. A bank dividing by N is high for N/2 source cycles and then low for N/2 source cycles.
- R3: On the first edge after reset is released, every bank output goes high on that same edge.
- R4: The four outputs of a bank carry identical values in every cycle.
- R5: Number the edges k = 0, 1, 2, … from the first edge after reset. A bank dividing by N rises exactly at the edges where k mod N = 0, so banks with different ratios rise together at every common multiple.
- R6: A select value is captured at reset and then only on edges where k mod 24 = 23. The new ratio governs output from edge k + 1 on, so no output pulse is ever shortened.
- R7: `sync` is high after edge k exactly when (k mod L) < M/2. Here L is the least common multiple of the bank A and bank C ratios, and M is the smaller of those two ratios.
- R8: The bank B select has no effect on `sync`.
- R9: R7 holds whether bank A or bank C is the faster bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast source clock (stand-in for the oscillator) |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_a | input | 2 | Bank A divide select |
| sel_b | input | 2 | Bank B divide select |
| sel_c | input | 2 | Bank C divide select |
| qa | output | 4 | Bank A clock outputs |
| qb | output | 4 | Bank B clock outputs |
| qc | output | 4 | Bank C clock outputs |
| sync | output | 1 | High during the faster bank's high phase at each A/C rising-edge coincidence |

## Verification
A corrupted phase counter shows up at the pins within one output period. It either splits a bank from the shared time base, so its rising edges drift off multiples of its ratio, or it changes a high or low run length. A select latched at the wrong time shows up as a ratio change somewhere other than a multiple of 24 edges. A fault in the alignment counter moves or stretches the `sync` window relative to the bank A and bank C edges, and this appears within one common period of those two banks. The bench predicts every output on every cycle from the edge count alone, so each of these faults is caught in the cycle it first appears.

// File: rtl/banked_div_pkg.sv
package banked_div_pkg;

  typedef logic [1:0] div_sel_t;

  localparam int unsigned NUM_BANKS = 3;
  localparam int unsigned BANK_A = 0;
  localparam int unsigned BANK_B = 1;
  localparam int unsigned BANK_C = 2;

  // ratio in units of the ratio step: select 00..11 -> 1..4
  function automatic int unsigned step_mult(input div_sel_t s);
    return 32'(s) + 32'd1;
  endfunction

  // least common multiple of two step multiples (1..4), in step units
  function automatic int unsigned pair_lcm_mult(input div_sel_t a, input div_sel_t b);
    int unsigned r;
    case ({a, b})
      4'b0000: r = 1;  4'b0001: r = 2;  4'b0010: r = 3;  4'b0011: r = 4;
      4'b0100: r = 2;  4'b0101: r = 2;  4'b0110: r = 6;  4'b0111: r = 4;
      4'b1000: r = 3;  4'b1001: r = 6;  4'b1010: r = 3;  4'b1011: r = 12;
      4'b1100: r = 4;  4'b1101: r = 4;  4'b1110: r = 12; default: r = 4;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/div_epoch.sv
module div_epoch
  import banked_div_pkg::*;
#(
  parameter int unsigned EPOCH = 24,
  parameter int unsigned CW    = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  div_sel_t [NUM_BANKS-1:0]      sel_req,
  output div_sel_t [NUM_BANKS-1:0]      sel_act,
  output logic                          wrap,
  output logic                          live
);

  logic [CW-1:0] tick;

  assign wrap = (tick == CW'(EPOCH - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick    <= '0;
      sel_act <= sel_req;
    end else if (wrap) begin
      tick    <= '0;
      sel_act <= sel_req;
    end else begin
      tick    <= tick + CW'(1);
    end
  end

  always_ff @(posedge clk) live <= rst_n;

  // R6
  tick_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick < CW'(EPOCH));

  // R6
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
    !$past(wrap) |-> $stable(sel_act));

endmodule

// File: rtl/div_bank.sv
module div_bank
  import banked_div_pkg::*;
#(
  parameter int unsigned STEP = 2,
  parameter int unsigned OUTS = 4,
  parameter int unsigned CW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wrap,
  input  div_sel_t        sel,
  output logic [OUTS-1:0] q,
  output logic            at_zero
);

  logic [CW-1:0] ratio;
  logic [CW-1:0] half;
  logic [CW-1:0] ph;
  logic          high_next;

  assign ratio     = CW'(step_mult(sel) * STEP);
  assign half      = ratio >> 1;
  assign high_next = (ph < half);
  assign at_zero   = (ph == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                             ph <= '0;
    else if (wrap || ph == ratio - CW'(1))  ph <= '0;
    else                                    ph <= ph + CW'(1);
  end

  for (genvar i = 0; i < OUTS; i++) begin : g_out
    always_ff @(posedge clk) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= high_next;
    end
  end

  // R2
  ph_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph < ratio);

endmodule

// File: rtl/div_sync.sv
module div_sync
  import banked_div_pkg::*;
#(
  parameter int unsigned STEP = 2,
  parameter int unsigned CW   = 5
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wrap,
  input  div_sel_t sel_a,
  input  div_sel_t sel_c,
  output logic     sync
);

  logic [CW-1:0] span;
  logic [CW-1:0] win;
  logic [CW-1:0] sp;
  div_sel_t      fast_sel;

  assign fast_sel = (sel_a < sel_c) ? sel_a : sel_c;
  assign span     = CW'(pair_lcm_mult(sel_a, sel_c) * STEP);
  assign win      = CW'(step_mult(fast_sel) * STEP) >> 1;

  always_ff @(posedge clk) begin
    if (!rst_n)                            sp <= '0;
    else if (wrap || sp == span - CW'(1))  sp <= '0;
    else                                   sp <= sp + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sync <= 1'b0;
    else        sync <= (sp < win);
  end

  // R7
  span_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp < span);

endmodule

// File: rtl/banked_clk_div.sv
module banked_clk_div
  import banked_div_pkg::*;
#(
  parameter int unsigned RATIO_STEP = 2,
  parameter int unsigned BANK_OUTS  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           sel_a,
  input  logic [1:0]           sel_b,
  input  logic [1:0]           sel_c,
  output logic [BANK_OUTS-1:0] qa,
  output logic [BANK_OUTS-1:0] qb,
  output logic [BANK_OUTS-1:0] qc,
  output logic                 sync
);

  // every ratio (1..4 steps) divides 12 steps
  localparam int unsigned EPOCH = 12 * RATIO_STEP;
  localparam int unsigned CW    = $clog2(EPOCH + 1);

  div_sel_t [NUM_BANKS-1:0]               sel_req;
  div_sel_t [NUM_BANKS-1:0]               sel_act;
  logic [NUM_BANKS-1:0][BANK_OUTS-1:0]    bank_q;
  logic [NUM_BANKS-1:0]                   bank_zero;
  logic                                   wrap;
  logic                                   live;

  assign sel_req[BANK_A] = sel_a;
  assign sel_req[BANK_B] = sel_b;
  assign sel_req[BANK_C] = sel_c;

  div_epoch #(.EPOCH(EPOCH), .CW(CW)) u_epoch (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_req (sel_req),
    .sel_act (sel_act),
    .wrap    (wrap),
    .live    (live)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    div_bank #(.STEP(RATIO_STEP), .OUTS(BANK_OUTS), .CW(CW)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wrap    (wrap),
      .sel     (sel_act[b]),
      .q       (bank_q[b]),
      .at_zero (bank_zero[b])
    );
  end

  div_sync #(.STEP(RATIO_STEP), .CW(CW)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .wrap  (wrap),
    .sel_a (sel_act[BANK_A]),
    .sel_c (sel_act[BANK_C]),
    .sync  (sync)
  );

  assign qa = bank_q[BANK_A];
  assign qb = bank_q[BANK_B];
  assign qc = bank_q[BANK_C];

  // R5
  epoch_align_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
    $past(wrap) |-> (&bank_zero));

  // R7
  sync_rise_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
    $rose(sync) |-> ($rose(qa[0]) && $rose(qc[0])));

  // R9
  sync_inside_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
    sync |-> (qa[0] && qc[0]));

endmodule

// File: tb/banked_clk_div_test.sv
`timescale 1ns/1ps
module banked_clk_div_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel_a = 2'b00, sel_b = 2'b00, sel_c = 2'b00;
  logic [3:0] qa, qb, qc;
  logic       sync;

  int n_tests = 0;
  int n_fail  = 0;
  int k = 0;
  logic [1:0] act_a, act_b, act_c;

  always #2.5 clk = ~clk;

  banked_clk_div uut (
    .clk(clk), .rst_n(rst_n), .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c),
    .qa(qa), .qb(qb), .qc(qc), .sync(sync)
  );

  function automatic int ratio(input logic [1:0] s);
    return (int'(s) + 1) * 2;
  endfunction

  function automatic int lcm(input int a, input int b);
    int x = a, y = b, t;
    while (y != 0) begin t = x % y; x = y; y = t; end
    return (a / x) * b;
  endfunction

  function automatic logic [3:0] bank_exp(input int kk, input logic [1:0] s);
    return ((kk % ratio(s)) < ratio(s) / 2) ? 4'hF : 4'h0;
  endfunction

  task automatic check(input string req, input logic [31:0] actv, input logic [31:0] expv);
    n_tests++;
    if (actv !== expv) begin
      n_fail++;
      $display("FAIL %s k=%0d actual=%h expected=%h", req, k, actv, expv);
    end
  endtask

  // R1: apply reset, check outputs low, release
  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 qa", 32'(qa), 0);
    check("R1 qb", 32'(qb), 0);
    check("R1 qc", 32'(qc), 0);
    check("R1 sync", 32'(sync), 0);
    act_a = sel_a; act_b = sel_b; act_c = sel_c;
    rst_n = 1'b1;
    k = 0;
  endtask

  // Predict every output each cycle (R2 R4 R5 R6 R7 R8 R9)
  task automatic run_cycles(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      logic [3:0] ea, eb, ec;
      logic       es;
      int         l, m;
      @(posedge clk);
      ea = bank_exp(k, act_a);
      eb = bank_exp(k, act_b);
      ec = bank_exp(k, act_c);
      l  = lcm(ratio(act_a), ratio(act_c));
      m  = (ratio(act_a) < ratio(act_c)) ? ratio(act_a) : ratio(act_c);
      es = ((k % l) < m / 2);
      if (k % 24 == 23) begin act_a = sel_a; act_b = sel_b; act_c = sel_c; end
      @(negedge clk);
      check({tag, " qa"}, 32'(qa), 32'(ea));
      check({tag, " qb"}, 32'(qb), 32'(eb));
      check({tag, " qc"}, 32'(qc), 32'(ec));
      check({tag, " sync"}, 32'(sync), 32'(es));
      k++;
    end
  endtask

  task automatic test_ratios();
    for (int s = 0; s < 4; s++) begin
      sel_a = 2'(s); sel_b = 2'(s); sel_c = 2'(s);
      do_reset();
      run_cycles(1, "R3");
      check("R3 first edge all high", 32'({qa, qb, qc}), 32'hFFF);
      run_cycles(47, "R2 R4");
    end
  endtask

  task automatic test_mixed();
    logic [5:0] combos [8] = '{6'b10_11_01, 6'b11_00_10, 6'b00_01_11, 6'b11_10_00,
                              6'b10_01_00, 6'b01_11_00, 6'b01_00_10, 6'b00_10_01};
    for (int c = 0; c < 8; c++) begin
      {sel_a, sel_b, sel_c} = combos[c];
      do_reset();
      run_cycles(72, "R5 R7 R9");
    end
  endtask

  task automatic test_midchange();
    sel_a = 2'b00; sel_b = 2'b00; sel_c = 2'b00;
    do_reset();
    run_cycles(10, "R6");
    sel_a = 2'b10; sel_b = 2'b11; sel_c = 2'b01;
    run_cycles(20, "R6");
    sel_a = 2'b11; sel_c = 2'b10;
    run_cycles(60, "R6");
  endtask

  task automatic test_b_only();
    sel_a = 2'b10; sel_b = 2'b00; sel_c = 2'b01;
    do_reset();
    run_cycles(30, "R8");
    sel_b = 2'b11;
    run_cycles(30, "R8");
    sel_b = 2'b01;
    run_cycles(40, "R8");
  endtask

  task automatic test_reset_midrun();
    sel_a = 2'b01; sel_b = 2'b10; sel_c = 2'b11;
    do_reset();
    run_cycles(13, "R1");
    do_reset();
    run_cycles(30, "R1 R3");
  endtask

  initial begin
    #1000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    test_ratios();
    test_mixed();
    test_midchange();
    test_b_only();
    test_reset_midrun();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule